// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Overflow and Carry Flags

This execution unit serves a 32-bit integer pipeline. Given an opcode, two register operands, a 16-bit immediate and the overflow-trap enable, it produces a 32-bit destination value, a register write strobe, a write of either the overflow flag or the carry flag, and a range-trap request. Signed operations report only through the overflow flag. Unsigned operations report only through the carry flag. A multiply finishes one cycle after it is accepted. A divide runs an iterative restoring sequence of one quotient bit per cycle.

The control is a three-state machine. `S_IDLE` waits for `start`. On an accepted start it moves to `S_DONE` for a multiply or a reserved opcode, and to `S_DIV` for a divide. `S_DIV` stays put until the divider reports its final iteration, then moves to `S_DONE`. `S_DONE` lasts one cycle, presents the committed results with `done`, and always returns to `S_IDLE`. Operands, opcode and trap enable are captured on acceptance. The ports may change freely afterwards.

Top module: `muldiv_flag_unit`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `result`, `rd_we`, `ovf_we`, `ovf_val`, `cry_we`, `cry_val` and `range_trap` are all 0.
- R2: For opcode 0 (signed multiply), `result` is the low 32 bits of the signed product. `ovf_we`=1, and `ovf_val` is 1 exactly when the signed product lies outside the signed 32-bit range. `cry_we`=0 and `rd_we`=1.
- R3: For opcode 1 (unsigned multiply), `result` is the low 32 bits of the unsigned product. `cry_we`=1, and `cry_val` is 1 exactly when the product exceeds 32 bits. `ovf_we`=0 and `rd_we`=1.
- R4: Opcode 2 (multiply by immediate) sign-extends `imm` to 32 bits and otherwise behaves as R2.
- R5: For opcode 3 (signed divide) with a nonzero divisor, `result` is the quotient truncated toward zero, `rd_we`=1, `ovf_we`=1 with `ovf_val`=0, and `cry_we`=0.
- R6: For opcode 3 with a zero divisor, `ovf_we`=1 with `ovf_val`=1, `rd_we`=0 and `cry_we`=0.
- R7: A signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000 with `ovf_val`=0 and `rd_we`=1.
- R8: For opcode 4 (unsigned divide), `cry_we`=1 and `cry_val` is 1 exactly when the divisor is zero. `rd_we` is 1 and `result` is the unsigned quotient only for a nonzero divisor. `ovf_we`=0.
- R9: `range_trap` is 1 in the `done` cycle exactly when the flag value written by the operation is 1 and `ovf_trap_en` was 1 when the operation was accepted. It is 0 in every other cycle.
- R10: With `start` high in cycle c, a multiply or reserved opcode raises `done` in cycle c+1, and a divide raises `done` in cycle c+33. `busy` is 1 from cycle c+1 through the `done` cycle.
- R11: A `start` that arrives while `busy` is 1 is ignored: the running operation completes with its own operands, and no second `done` follows.
- R12: Opcodes 5, 6 and 7 raise `done` in cycle c+1 with no register write, no flag write and no trap.
- R13: Outside the single `done` cycle, `result`, `rd_we`, `ovf_we`, `ovf_val`, `cry_we`, `cry_val` and `range_trap` are 0. `done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a new operation when idle |
| op | input | 3 | Opcode: 0 mul, 1 mulu, 2 muli, 3 div, 4 divu, 5-7 reserved |
| opa | input | 32 | First operand (dividend, multiplicand) |
| opb | input | 32 | Second operand (divisor, multiplier) |
| imm | input | 16 | Immediate multiplier for opcode 2 |
| ovf_trap_en | input | 1 | Overflow-trap enable, sampled on acceptance |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Destination value |
| rd_we | output | 1 | Destination register write |
| ovf_we | output | 1 | Overflow flag write |
| ovf_val | output | 1 | Overflow flag value |
| cry_we | output | 1 | Carry flag write |
| cry_val | output | 1 | Carry flag value |
| range_trap | output | 1 | Range-trap request pulse |

## Verification
The bench crosses every opcode with a grid of edge operands: zero, one, all ones, the most negative and most positive values, and half-word boundaries. This exposes a signed-overflow detector that tests only the high half and misses a low word that changes sign. A flag written to the wrong register, or written by both signed and unsigned forms, shows up the same way. A zero divisor is checked for the absence of a register write. Without that check, a divider would write its all-ones garbage quotient. The most-negative-by-minus-one case would trip a design that flags it or saturates it. A start issued mid-divide checks that operands are latched and that no extra completion appears. Latency and trap gating are checked on every operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_MULU = 3'd1,
        OP_MULI = 3'd2,
        OP_DIV  = 3'd3,
        OP_DIVU = 3'd4
    } mdu_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DIV  = 2'd1,
        S_DONE = 2'd2
    } mdu_state_e;
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_signed,
    output logic [XLEN-1:0] lo,
    output logic            ovf
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   prod;
    logic [XLEN:0]   sign_span;

    always_comb begin
        if (is_signed)
            prod = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
        else
            prod = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
    end

    assign sign_span = prod[PW-1:XLEN-1];
    assign lo        = prod[XLEN-1:0];
    assign ovf       = is_signed ? !((&sign_span) || (~|sign_span))
                                 : (|prod[PW-1:XLEN]);
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            is_signed,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quot,
    output logic            last
);
    localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(XLEN - 1);

    logic            run_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN:0]   rem_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] den_q;
    logic            neg_q;
    logic [XLEN:0]   shifted;
    logic [XLEN:0]   trial;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;

    assign mag_a   = (is_signed && dividend[XLEN-1]) ? -dividend : dividend;
    assign mag_b   = (is_signed && divisor[XLEN-1])  ? -divisor  : divisor;
    assign shifted = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
    assign trial   = shifted - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            neg_q <= 1'b0;
        end else if (load) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            rem_q <= '0;
            quo_q <= mag_a;
            den_q <= mag_b;
            neg_q <= is_signed && (dividend[XLEN-1] ^ divisor[XLEN-1]);
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT)
                run_q <= 1'b0;
            if (!trial[XLEN]) begin
                rem_q <= trial;
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    assign last = run_q && (cnt_q == LAST_CNT);
    assign quot = neg_q ? -quo_q : quo_q;

    // R11: the controller never reloads an iteration in progress
    assert_no_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !run_q);
endmodule

// File: rtl/muldiv_flag_unit.sv
module muldiv_flag_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [IMM_W-1:0] imm,
    input  logic             ovf_trap_en,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  result,
    output logic             rd_we,
    output logic             ovf_we,
    output logic             ovf_val,
    output logic             cry_we,
    output logic             cry_val,
    output logic             range_trap
);
    localparam int IMM_PAD = XLEN - IMM_W;

    mdu_state_e      state_q, state_d;
    logic [2:0]      op_q;
    logic            en_q;
    logic            dz_q;
    logic [XLEN-1:0] mres_q;
    logic            mflag_q;

    logic            accept;
    logic            op_is_div;
    logic [XLEN-1:0] mul_b;
    logic [XLEN-1:0] mul_lo;
    logic            mul_ovf;
    logic [XLEN-1:0] div_quot;
    logic            div_last;

    assign accept    = (state_q == S_IDLE) && start;
    assign op_is_div = (op == OP_DIV) || (op == OP_DIVU);
    assign mul_b     = (op == OP_MULI) ? {{IMM_PAD{imm[IMM_W-1]}}, imm} : opb;

    mdu_mult #(.XLEN(XLEN)) u_mult (
        .a         (opa),
        .b         (mul_b),
        .is_signed (op != OP_MULU),
        .lo        (mul_lo),
        .ovf       (mul_ovf)
    );

    mdu_div #(.XLEN(XLEN)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && op_is_div),
        .is_signed (op == OP_DIV),
        .dividend  (opa),
        .divisor   (opb),
        .quot      (div_quot),
        .last      (div_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = op_is_div ? S_DIV : S_DONE;
            S_DIV:   if (div_last) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // operation capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            en_q    <= 1'b0;
            dz_q    <= 1'b0;
            mres_q  <= '0;
            mflag_q <= 1'b0;
        end else if (accept) begin
            op_q    <= op;
            en_q    <= ovf_trap_en;
            dz_q    <= (opb == '0);
            mres_q  <= mul_lo;
            mflag_q <= mul_ovf;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        done       = 1'b0;
        result     = '0;
        rd_we      = 1'b0;
        ovf_we     = 1'b0;
        ovf_val    = 1'b0;
        cry_we     = 1'b0;
        cry_val    = 1'b0;
        if (state_q == S_DONE) begin
            done = 1'b1;
            unique case (op_q)
                OP_MUL, OP_MULI: begin
                    result  = mres_q;
                    rd_we   = 1'b1;
                    ovf_we  = 1'b1;
                    ovf_val = mflag_q;
                end
                OP_MULU: begin
                    result  = mres_q;
                    rd_we   = 1'b1;
                    cry_we  = 1'b1;
                    cry_val = mflag_q;
                end
                OP_DIV: begin
                    result  = dz_q ? '0 : div_quot;
                    rd_we   = !dz_q;
                    ovf_we  = 1'b1;
                    ovf_val = dz_q;
                end
                OP_DIVU: begin
                    result  = dz_q ? '0 : div_quot;
                    rd_we   = !dz_q;
                    cry_we  = 1'b1;
                    cry_val = dz_q;
                end
                default: ;
            endcase
        end
        range_trap = en_q && (ovf_val || cry_val);
    end

    // R2/R3: an operation writes at most one of the two flags
    assert_single_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_we && cry_we));

    // R9: the trap request appears only with completion
    assert_trap_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        range_trap |-> done);

    // R13: completion is a single-cycle strobe
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: no architectural write outside the completion cycle
    assert_write_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || ovf_we || cry_we) |-> done);

    // R11: captured opcode is held while an operation is in flight
    assert_op_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(op_q));

    // R10: a divide completes only after the iterative phase
    assert_div_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_DIV || op_q == OP_DIVU)) |-> $past(state_q) == S_DIV);
endmodule

// File: tb/sim_muldiv_flag_unit.sv
module sim_muldiv_flag_unit;
    localparam int XLEN  = 32;
    localparam int IMM_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       op = '0;
    logic [XLEN-1:0]  opa = '0;
    logic [XLEN-1:0]  opb = '0;
    logic [IMM_W-1:0] imm = '0;
    logic             ovf_trap_en = 1'b0;
    logic             busy, done, rd_we, ovf_we, ovf_val, cry_we, cry_val, range_trap;
    logic [XLEN-1:0]  result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    muldiv_flag_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .imm(imm), .ovf_trap_en(ovf_trap_en), .busy(busy), .done(done),
        .result(result), .rd_we(rd_we), .ovf_we(ovf_we), .ovf_val(ovf_val),
        .cry_we(cry_we), .cry_val(cry_val), .range_trap(range_trap)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] quiet_vec();
        return {27'd0, done, rd_we, ovf_we, ovf_val, cry_we, cry_val, range_trap, result};
    endfunction

    // drive one operation, return cycles until done (sampled at negedge)
    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im, input logic en, output int lat);
        @(negedge clk);
        op = o; opa = a; opb = b; imm = im; ovf_trap_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        opa = ~a; opb = ~b;
        lat = 1;
        while (!done && lat < 100) begin
            chk("R13 quiet while waiting", quiet_vec(), 64'd0);
            chk("R10 busy while waiting", {63'd0, busy}, 64'd1);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] im, input logic en);
        longint          p, q;
        longint unsigned pu;
        logic [31:0]     bx;
        logic [31:0]     eres;
        logic            ewe, eovw, eovv, ecyw, ecyv, etrap;
        int              elat, lat;
        string           tag;
        eres = '0; ewe = 0; eovw = 0; eovv = 0; ecyw = 0; ecyv = 0; elat = 1;
        case (o)
            3'd0: begin
                tag = "R2 mul";
                p = longint'($signed(a)) * longint'($signed(b));
                eres = p[31:0]; ewe = 1; eovw = 1;
                eovv = (p > 64'sd2147483647) || (p < -64'sd2147483648);
            end
            3'd1: begin
                tag = "R3 mulu";
                pu = {32'd0, a} * {32'd0, b};
                eres = pu[31:0]; ewe = 1; ecyw = 1; ecyv = |pu[63:32];
            end
            3'd2: begin
                tag = "R4 muli";
                bx = {{16{im[15]}}, im};
                p = longint'($signed(a)) * longint'($signed(bx));
                eres = p[31:0]; ewe = 1; eovw = 1;
                eovv = (p > 64'sd2147483647) || (p < -64'sd2147483648);
            end
            3'd3: begin
                elat = 33; eovw = 1;
                if (b == 0) begin
                    tag = "R6 div by zero"; eovv = 1;
                end else begin
                    tag = (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ? "R7 div min/-1" : "R5 div";
                    q = longint'($signed(a)) / longint'($signed(b));
                    eres = q[31:0]; ewe = 1;
                end
            end
            3'd4: begin
                tag = "R8 divu"; elat = 33; ecyw = 1;
                if (b == 0) ecyv = 1;
                else begin
                    eres = a / b; ewe = 1;
                end
            end
            default: tag = "R12 reserved";
        endcase
        etrap = en && (eovv || ecyv);
        run_op(o, a, b, im, en, lat);
        chk({tag, " latency R10"}, 64'(lat), 64'(elat));
        chk({tag, " result"}, {32'd0, result}, {32'd0, eres});
        chk({tag, " strobes"}, {59'd0, rd_we, ovf_we, ovf_val, cry_we, cry_val},
            {59'd0, ewe, eovw, eovv, ecyw, ecyv});
        chk({tag, " trap R9"}, {63'd0, range_trap}, {63'd0, etrap});
        @(negedge clk);
        chk({tag, " after done R13"}, quiet_vec(), 64'd0);
    endtask

    // watchdog
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    logic [31:0] vals [13] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7, 32'hFFFF_FFFF,
                               32'hFFFF_FFFE, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_0000,
                               32'h0000_FFFF, 32'h1234_5678, 32'hFFFF_0000};

    initial begin
        int lat;
        int ndone;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {busy, quiet_vec()[62:0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {busy, quiet_vec()[62:0]}, 64'd0);

        // sweep every defined opcode over the operand grid
        for (int i = 0; i < 13; i++) begin
            for (int j = 0; j < 13; j++) begin
                for (int o = 0; o < 5; o++) begin
                    check_op(3'(o), vals[i], vals[j], vals[j][15:0], 1'((i + j + o) & 1));
                end
            end
        end

        // R7 explicit with trap enabled, R6 and R8 zero divisors with trap enabled
        check_op(3'd3, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b1);
        check_op(3'd3, 32'hFFFF_FFF9, 32'h0, 16'h0, 1'b1);
        check_op(3'd4, 32'h0000_0009, 32'h0, 16'h0, 1'b1);
        check_op(3'd3, 32'hFFFF_FFF9, 32'h2, 16'h0, 1'b1);

        // R12 reserved opcodes
        for (int o = 5; o < 8; o++) begin
            check_op(3'(o), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h7FFF, 1'b1);
        end

        // R11 start while busy is ignored
        @(negedge clk);
        op = 3'd4; opa = 32'd100; opb = 32'd7; ovf_trap_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (lat == 5) begin
                op = 3'd0; opa = 32'd3; opb = 32'd5; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R11 divide latency kept", 64'(lat), 64'd33);
        chk("R11 divide result kept", {32'd0, result}, 64'd14);
        ndone = 0;
        repeat (5) begin
            @(negedge clk);
            if (done) ndone++;
        end
        chk("R11 no second completion", 64'(ndone), 64'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule